// File: doc/BRIEF.md
# Daisy-Chain Bus Arbitration Node

This block is the per-device interface on a bus whose ownership is granted through a daisy chain. A central grant line enters the first device. Each device either passes that grant to the next device or absorbs it and takes the bus. The node watches three inputs: its local wish to use the bus, the grant arriving from upstream, and the shared busy line. It drives four outputs: a request toward the grant source, the grant toward the next device downstream, its share of the busy line, and a local owner flag that tells the device logic it may use the bus.

A four-state machine handles the behaviour. The states are idle, forwarding the grant, requesting, and owning. The node takes ownership only when it sees a low-to-high transition on its incoming grant. It never raises its request while that grant is already high. Because of this rule, a grant that stays high can never leave a requester waiting for an edge that will not arrive. When the grant edge comes while the busy line is still active, the node remembers the edge, keeps its request up, and takes the bus once the busy line clears, provided the grant is still present. The grant source is expected to hold the chain grant high for as long as any request is active.

All outputs are decoded from registered state. Each node therefore adds one clock of delay to a grant travelling along the chain.

Top module: `bus_arb_node`

## Requirements
- R1: While `rst` is high, at the first clock edge and afterwards, all four outputs are low, whatever the inputs are.
- R2: When the node is idle, `bus_want` is low and `grant_in` is high, `grant_out` goes high one clock later. It stays high while `grant_in` stays high, and it goes low one clock after `grant_in` falls.
- R3: When the node is idle and `bus_want` is high while `grant_in` is low, `req_out` goes high one clock later. While the node is requesting, `grant_out` stays low.
- R4: `req_out` rises only if `grant_in` was low at the clock edge that raised it. A node that wants the bus while `grant_in` is high keeps `req_out` low and keeps forwarding the grant. Once `grant_in` falls, the node requests one clock later.
- R5: A requesting node that sees `grant_in` rise while `busy_in` is low asserts `owner` and `busy_drive` one clock later and drops `req_out`.
- R6: If `busy_in` is high when the grant edge arrives, the node keeps requesting. It takes the bus one clock after `busy_in` falls, provided `grant_in` is still high. If `grant_in` falls before that, the remembered edge is discarded, and the node waits for a new rising edge.
- R7: A requesting node whose `bus_want` falls drops `req_out` one clock later. If `grant_in` is high at that point, the node then forwards the grant.
- R8: While the node owns the bus, `owner` and `busy_drive` stay high whatever `grant_in` does. Both fall one clock after `bus_want` falls.
- R9: `req_out` and `grant_out` are never high together. `owner` is never high together with either of them.
- R10: In a chain of nodes that all request at once, the bus goes to the nodes in chain order as each one releases it. At most one node holds `owner` in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_want | input | 1 | Local device needs the bus |
| grant_in | input | 1 | Grant arriving from upstream |
| busy_in | input | 1 | Shared bus-busy line as sensed |
| req_out | output | 1 | Bus request toward the grant source |
| grant_out | output | 1 | Grant forwarded downstream |
| busy_drive | output | 1 | This node's contribution to the busy line |
| owner | output | 1 | Node holds the bus |

## Verification
The hardest situation to reach is a grant edge that arrives while another master still holds the busy line. It is harder still when that grant then drops and rises again before the bus is released, because the remembered edge must be discarded and a fresh one required. The directed stimulus builds this case directly on a single node by holding `busy_in` while toggling `grant_in`. A three-node chain, fed by a grant source that stays high while any request is active, then checks the hand-over order and that ownership is never shared.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_REQ  = 2'd2,
        ST_OWN  = 2'd3
    } arb_state_e;

    typedef struct packed {
        logic want;
        logic grant;
        logic rise;
        logic busy;
    } arb_in_s;

    typedef struct packed {
        logic req;
        logic fwd;
        logic busy;
        logic own;
    } arb_out_s;

    function automatic arb_out_s arb_decode(arb_state_e s);
        arb_out_s o;
        o = '0;
        unique case (s)
            ST_FWD:  o.fwd = 1'b1;
            ST_REQ:  o.req = 1'b1;
            ST_OWN:  begin
                o.busy = 1'b1;
                o.own  = 1'b1;
            end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/arb_grant_edge.sv
module arb_grant_edge (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    output logic rise
);

    logic grant_q;

    always_ff @(posedge clk) begin
        if (rst) grant_q <= 1'b0;
        else     grant_q <= grant;
    end

    assign rise = grant & ~grant_q;

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  arb_in_s    in_s,
    output arb_state_e state
);

    arb_state_e state_n;
    logic       edge_held, edge_held_n;
    logic       armed;

    assign armed = (in_s.rise | edge_held) & in_s.grant;

    always_comb begin
        state_n     = state;
        edge_held_n = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_s.grant)     state_n = ST_FWD;
                else if (in_s.want) state_n = ST_REQ;
            end
            ST_FWD: begin
                if (!in_s.grant) state_n = in_s.want ? ST_REQ : ST_IDLE;
            end
            ST_REQ: begin
                if (!in_s.want) begin
                    state_n = ST_IDLE;
                end else if (armed && !in_s.busy) begin
                    state_n = ST_OWN;
                end else if (armed) begin
                    edge_held_n = 1'b1;
                end
            end
            ST_OWN: begin
                if (!in_s.want) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            edge_held <= 1'b0;
        end else begin
            state     <= state_n;
            edge_held <= edge_held_n;
        end
    end

    // R5
    own_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OWN && $past(state) != ST_OWN) |-> ($past(in_s.grant) && !$past(in_s.busy)));

    // R6
    held_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        edge_held |-> (state == ST_REQ));

endmodule

// File: rtl/arb_outdec.sv
module arb_outdec
    import arb_pkg::*;
(
    input  arb_state_e state,
    output arb_out_s   out_s
);

    assign out_s = arb_decode(state);

endmodule

// File: rtl/bus_arb_node.sv
module bus_arb_node
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_want,
    input  logic grant_in,
    input  logic busy_in,
    output logic req_out,
    output logic grant_out,
    output logic busy_drive,
    output logic owner
);

    logic       grant_rise;
    arb_in_s    in_s;
    arb_state_e state;
    arb_out_s   out_s;

    arb_grant_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .grant (grant_in),
        .rise  (grant_rise)
    );

    always_comb begin
        in_s.want  = bus_want;
        in_s.grant = grant_in;
        in_s.rise  = grant_rise;
        in_s.busy  = busy_in;
    end

    arb_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .in_s  (in_s),
        .state (state)
    );

    arb_outdec u_dec (
        .state (state),
        .out_s (out_s)
    );

    assign req_out    = out_s.req;
    assign grant_out  = out_s.fwd;
    assign busy_drive = out_s.busy;
    assign owner      = out_s.own;

    // R4
    no_req_under_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_out) |-> !$past(grant_in));

    // R5
    own_on_free_bus_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(owner) |-> ($past(grant_in) && !$past(busy_in)));

    // R8
    release_on_want_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(owner) |-> !$past(bus_want));

    // R8
    owner_drives_busy_chk: assert property (@(posedge clk) disable iff (rst)
        owner |-> busy_drive);

    // R9
    exclusive_out_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({req_out, grant_out, owner}) <= 1);

endmodule

// File: tb/test_bus_arb_node.sv
module test_bus_arb_node;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, want, gin, busy;
    logic req, gout, bdrv, ack;

    bus_arb_node i_bus_arb_node (
        .clk(clk), .rst(rst), .bus_want(want), .grant_in(gin), .busy_in(busy),
        .req_out(req), .grant_out(gout), .busy_drive(bdrv), .owner(ack)
    );

    // three-node chain with a grant source model
    logic [2:0] cw, creq, cbd, cack;
    logic [3:0] gch;
    logic       g0, cbusy;
    assign gch[0] = g0;
    assign cbusy  = |cbd;

    for (genvar k = 0; k < 3; k++) begin : g_node
        bus_arb_node u_node (
            .clk(clk), .rst(rst), .bus_want(cw[k]), .grant_in(gch[k]), .busy_in(cbusy),
            .req_out(creq[k]), .grant_out(gch[k+1]), .busy_drive(cbd[k]), .owner(cack[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) g0 <= 1'b0;
        else     g0 <= |creq;
    end

    int vectors = 0, miscompares = 0, multi_own = 0;
    bit done = 0;

    always @(negedge clk) if (!rst && $countones(cack) > 1) multi_own++;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [3:0] exp);
        logic [3:0] got;
        got = {req, gout, bdrv, ack};
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: {req,gout,busy,own} got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic settle();
        want = 0; gin = 0; busy = 0;
        tick(3);
    endtask

    task automatic t_reset();
        rst = 1; want = 1; gin = 1; busy = 0;
        tick(3);
        check("R1 reset outputs", 4'b0000);
        gin = 0; want = 0;
        rst = 0;
        tick(1);
        check("R1 idle after reset", 4'b0000);
    endtask

    task automatic t_forward();
        settle();
        gin = 1; tick(1);
        check("R2 forward starts", 4'b0100);
        tick(2);
        check("R2 forward held", 4'b0100);
        gin = 0; tick(1);
        check("R2 forward ends", 4'b0000);
    endtask

    task automatic t_take();
        settle();
        want = 1; tick(1);
        check("R3 request", 4'b1000);
        tick(2);
        check("R3 request held", 4'b1000);
        gin = 1; tick(1);
        check("R5 take on edge", 4'b0011);
        gin = 0; tick(2);
        check("R8 hold after grant drop", 4'b0011);
        want = 0; tick(1);
        check("R8 release", 4'b0000);
    endtask

    task automatic t_no_req_under_grant();
        settle();
        gin = 1; tick(1);
        want = 1; tick(3);
        check("R4 no request under grant", 4'b0100);
        gin = 0; tick(1);
        check("R4 request after grant falls", 4'b1000);
        gin = 1; tick(1);
        check("R5 take after late request", 4'b0011);
    endtask

    task automatic t_defer();
        settle();
        want = 1; tick(1);
        busy = 1; gin = 1; tick(2);
        check("R6 defer while busy", 4'b1000);
        busy = 0; tick(1);
        check("R6 take after busy clears", 4'b0011);
    endtask

    task automatic t_held_edge_cleared();
        settle();
        want = 1; tick(1);
        busy = 1; gin = 1; tick(1);
        gin = 0; tick(1);
        busy = 0; tick(2);
        check("R6 stale edge discarded", 4'b1000);
        gin = 1; tick(1);
        check("R6 fresh edge taken", 4'b0011);
    endtask

    task automatic t_withdraw();
        settle();
        want = 1; tick(1);
        want = 0; tick(1);
        check("R7 withdraw", 4'b0000);
        want = 1; tick(1);
        busy = 1; gin = 1; tick(1);
        want = 0; tick(1);
        check("R7 withdraw under grant", 4'b0000);
        tick(1);
        check("R7 forward after withdraw", 4'b0100);
    endtask

    task automatic t_chain();
        settle();
        cw = 3'b111;
        for (int n = 0; n < 3; n++) begin
            int waited = 0;
            while (cack == 3'b000 && waited < 40) begin
                tick(1);
                waited++;
            end
            vectors++;
            if (cack !== 3'(1 << n)) begin
                miscompares++;
                $display("FAIL R10 owner order: got %b expected %b", cack, 3'(1 << n));
            end
            tick(3);
            vectors++;
            if (cack !== 3'(1 << n)) begin
                miscompares++;
                $display("FAIL R10 ownership held: got %b expected %b", cack, 3'(1 << n));
            end
            cw[n] = 1'b0;
            tick(1);
        end
        tick(5);
        vectors++;
        if (multi_own != 0 || cack != 3'b000) begin
            miscompares++;
            $display("FAIL R10 single owner: got %0d overlaps owners %b expected 0 000",
                     multi_own, cack);
        end
    endtask

    initial begin
        cw = 3'b000;
        t_reset();
        t_forward();
        t_take();
        t_no_req_under_grant();
        t_defer();
        t_held_edge_cleared();
        t_withdraw();
        t_chain();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule